// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the address of the next microword for a microcoded controller. It holds a 4-bit microprogram counter that drives the control-store address. On every clock edge it looks at fields of the current microword: a 2-bit branch-function code, a 2-bit condition-select code and a 4-bit branch target. It also looks at two status inputs from the rest of the machine, a start request and a flag that says the data is non-zero.

The condition-select code picks one status term. The branch-function code then turns that term into two counter controls, load and enable. With these controls the counter holds, advances by one, or loads the branch target. The done bit of the current microword passes straight through to an output. Address 0 is the idle location that a reset selects. A microprogram normally waits there on the start request.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `upc_addr` becomes 0 after that edge.
- R2: With branch function 2'b00, the address advances from n to n+1 on every edge, whatever the condition is.
- R3: With branch function 2'b01, the address advances to n+1 when the selected condition is 1 and stays at n when it is 0.
- R4: With branch function 2'b10, the address loads `br_target` when the selected condition is 1 and stays at n when it is 0.
- R5: With branch function 2'b11, the address loads `br_target` when the selected condition is 1 and goes to n+1 when it is 0.
- R6: Condition select 2'b00 gives a constant 1, 2'b01 gives `start_req`, 2'b10 gives `data_nz`, and 2'b11 gives a constant 0. Code 2'b11 therefore never causes a load or a conditional advance.
- R7: Advancing from address 15 gives address 0.
- R8: `done_out` equals `done_in` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bf_code | input | 2 | Branch-function field of the current microword |
| cs_code | input | 2 | Condition-select field of the current microword |
| br_target | input | 4 | Branch-target field of the current microword |
| start_req | input | 1 | Start request status |
| data_nz | input | 1 | Data-not-zero status |
| done_in | input | 1 | Done bit of the current microword |
| upc_addr | output | 4 | Current microprogram address |
| done_out | output | 1 | Done bit passed through |

## Verification
The whole state of this block is the counter. A wrong load, enable or condition choice shows up on `upc_addr` on the first edge after the faulty cycle. From then on the error persists, because every later address is built from the wrong one. For that reason the bench compares the address against a reference model on every cycle, rather than only at the end. Condition code 2'b11 and the hold cases get their own directed checks, because a wrong value there would only show as a missing stall or an extra step.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int unsigned UADDR_W = 4;

    typedef enum logic [1:0] {
        BF_NEXT      = 2'b00,
        BF_WAIT      = 2'b01,
        BF_JUMP      = 2'b10,
        BF_JUMP_ELSE = 2'b11
    } brfn_e;

    typedef enum logic [1:0] {
        CS_ALWAYS  = 2'b00,
        CS_START   = 2'b01,
        CS_NONZERO = 2'b10,
        CS_NEVER   = 2'b11
    } csel_e;

    typedef struct packed {
        logic load;
        logic enable;
    } cnt_ctl_t;

    // Map branch function and selected condition to counter controls
    function automatic cnt_ctl_t decode_ctl(brfn_e f, logic c);
        cnt_ctl_t r;
        case (f)
            BF_NEXT:      begin r.load = 1'b0; r.enable = 1'b1; end
            BF_WAIT:      begin r.load = 1'b0; r.enable = c;    end
            BF_JUMP:      begin r.load = 1'b1; r.enable = c;    end
            default:      begin r.load = c;    r.enable = 1'b1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel
    import mseq_pkg::*;
(
    input  csel_e sel,
    input  logic  start_req,
    input  logic  data_nz,
    output logic  cond
);
    always_comb begin
        case (sel)
            CS_ALWAYS:  cond = 1'b1;
            CS_START:   cond = start_req;
            CS_NONZERO: cond = data_nz;
            default:    cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_ctl_dec.sv
module mseq_ctl_dec
    import mseq_pkg::*;
(
    input  brfn_e    fn,
    input  logic     cond,
    output cnt_ctl_t ctl
);
    always_comb ctl = decode_ctl(fn, cond);
endmodule

// File: rtl/mseq_upc.sv
module mseq_upc #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         enable,
    input  logic [W-1:0] target,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (enable)
            q <= load ? target : q + ONE;
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int unsigned AW = UADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bf_code,
    input  logic [1:0]    cs_code,
    input  logic [AW-1:0] br_target,
    input  logic          start_req,
    input  logic          data_nz,
    input  logic          done_in,
    output logic [AW-1:0] upc_addr,
    output logic          done_out
);
    logic     cond;
    cnt_ctl_t ctl;

    mseq_cond_sel u_sel (
        .sel       (csel_e'(cs_code)),
        .start_req (start_req),
        .data_nz   (data_nz),
        .cond      (cond)
    );

    mseq_ctl_dec u_dec (
        .fn   (brfn_e'(bf_code)),
        .cond (cond),
        .ctl  (ctl)
    );

    mseq_upc #(.W(AW)) u_upc (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.load),
        .enable (ctl.enable),
        .target (br_target),
        .q      (upc_addr)
    );

    assign done_out = done_in;
endmodule

// File: rtl/mseq_top_chk.sv
module mseq_top_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    bf_code,
    input logic [1:0]    cs_code,
    input logic [AW-1:0] br_target,
    input logic          start_req,
    input logic          data_nz,
    input logic          done_in,
    input logic [AW-1:0] upc_addr,
    input logic          done_out
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q === 1'b1)
            p_reset_zero_r1: assert (upc_addr == '0);
    end

    always_comb begin
        p_done_pass_r8: assert (done_out == done_in);
    end

    p_always_step_r2: assert property (@(posedge clk) disable iff (rst)
        bf_code == 2'b00 |=> upc_addr == AW'($past(upc_addr) + 1'b1));

    p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bf_code == 2'b01 && cs_code == 2'b10 && !data_nz) |=> $stable(upc_addr));

    p_jump_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (bf_code == 2'b10 && cs_code == 2'b01 && start_req) |=> upc_addr == $past(br_target));

    p_jump_else_r5: assert property (@(posedge clk) disable iff (rst)
        (bf_code == 2'b11 && cs_code == 2'b00) |=> upc_addr == $past(br_target));

    p_never_cond_r6: assert property (@(posedge clk) disable iff (rst)
        (bf_code == 2'b10 && cs_code == 2'b11) |=> $stable(upc_addr));

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (bf_code == 2'b00 && upc_addr == '1) |=> upc_addr == '0);
endmodule

bind mseq_top mseq_top_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bf_code   (bf_code),
    .cs_code   (cs_code),
    .br_target (br_target),
    .start_req (start_req),
    .data_nz   (data_nz),
    .done_in   (done_in),
    .upc_addr  (upc_addr),
    .done_out  (done_out)
);

// File: tb/mseq_top_tb_top.sv
module mseq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bf_code, cs_code;
    logic [3:0] br_target;
    logic       start_req, data_nz, done_in;
    logic [3:0] upc_addr;
    logic       done_out;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_addr;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    mseq_top dut_i (
        .clk(clk), .rst(rst), .bf_code(bf_code), .cs_code(cs_code),
        .br_target(br_target), .start_req(start_req), .data_nz(data_nz),
        .done_in(done_in), .upc_addr(upc_addr), .done_out(done_out)
    );

    function automatic logic cond_of(logic [1:0] cs, logic s, logic nz);
        case (cs)
            2'b00:   return 1'b1;
            2'b01:   return s;
            2'b10:   return nz;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] model_next(logic [3:0] cur, logic [1:0] bf,
            logic [1:0] cs, logic [3:0] tgt, logic s, logic nz);
        logic c;
        c = cond_of(cs, s, nz);
        case (bf)
            2'b00:   return cur + 4'd1;
            2'b01:   return c ? cur + 4'd1 : cur;
            2'b10:   return c ? tgt : cur;
            default: return c ? tgt : cur + 4'd1;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] bf, logic [1:0] cs);
        if (cs == 2'b11 && bf != 2'b00) return "R6";
        case (bf)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_addr(string tag);
        checks++;
        if (upc_addr !== exp_addr) begin
            errors++;
            $display("FAIL %s: upc_addr=%0d expected=%0d", tag, upc_addr, exp_addr);
        end
    endtask

    task automatic check_done();
        checks++;
        if (done_out !== done_in) begin
            errors++;
            $display("FAIL R8: done_out=%0b expected=%0b", done_out, done_in);
        end
    endtask

    // Drive one microword at the falling edge, then check just after the next falling edge
    task automatic step(logic [1:0] bf, logic [1:0] cs, logic [3:0] tgt,
                        logic s, logic nz, logic dn);
        string t;
        bf_code = bf; cs_code = cs; br_target = tgt;
        start_req = s; data_nz = nz; done_in = dn;
        #1;
        check_done();
        exp_addr = model_next(exp_addr, bf, cs, tgt, s, nz);
        t = tag_of(bf, cs);
        if (exp_addr == 4'd0 && bf != 2'b10 && !(bf == 2'b11 && cond_of(cs, s, nz)))
            t = {t, "/R7"};
        @(negedge clk);
        check_addr(t);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        rst = 1'b1; bf_code = 2'b00; cs_code = 2'b00; br_target = 4'd0;
        start_req = 1'b0; data_nz = 1'b0; done_in = 1'b0;
        @(negedge clk); @(negedge clk);
        exp_addr = 4'd0;
        check_addr("R1");
        rst = 1'b0;

        // idle wait on start, then start
        step(2'b01, 2'b01, 4'd9, 1'b0, 1'b1, 1'b0);   // R3 hold
        step(2'b01, 2'b01, 4'd9, 1'b1, 1'b0, 1'b0);   // R3 advance
        step(2'b10, 2'b10, 4'd7, 1'b1, 1'b0, 1'b0);   // R4 hold
        step(2'b10, 2'b10, 4'd7, 1'b0, 1'b1, 1'b1);   // R4 jump
        step(2'b11, 2'b01, 4'd2, 1'b0, 1'b1, 1'b0);   // R5 fall through
        step(2'b11, 2'b10, 4'd2, 1'b0, 1'b1, 1'b0);   // R5 jump
        // R6: code 11 never fires, even with both status bits high
        step(2'b10, 2'b11, 4'd12, 1'b1, 1'b1, 1'b0);
        step(2'b01, 2'b11, 4'd12, 1'b1, 1'b1, 1'b0);
        step(2'b11, 2'b11, 4'd12, 1'b1, 1'b1, 1'b0);
        // R7: load 15 then step to wrap
        step(2'b11, 2'b00, 4'd15, 1'b0, 1'b0, 1'b0);
        step(2'b00, 2'b10, 4'd3, 1'b0, 1'b0, 1'b1);
        step(2'b11, 2'b00, 4'd15, 1'b0, 1'b0, 1'b0);
        step(2'b01, 2'b00, 4'd3, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            step(2'($urandom()), 2'($urandom()), 4'($urandom()),
                 1'($urandom()), 1'($urandom()), 1'($urandom()));
            if (i == 1500) begin
                rst = 1'b1;
                @(negedge clk);
                exp_addr = 4'd0;
                check_addr("R1");
                rst = 1'b0;
            end
        end
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: finished=0 expected=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule